// File: doc/BRIEF.md
# Extended Inter-Packet Gap Timer

This block enforces the minimum idle time between two transmitted frames on a full-duplex MAC transmit path. The transmit engine pulses `tx_end` when a frame finishes. The block then holds `tx_permit` low until the configured gap has passed. Time is counted in byte times: `byte_tick` is a one-cycle enable that marks one byte time at the line rate. Any frame waiting to go out must be held back until `tx_permit` returns high.

The gap has two modes. In normal mode only the 5-bit `gap_base` field is used, and the gap is 96 bit times or less. In extended mode, which is meant only for full-duplex links, the 3-bit `gap_ext` field sits above `gap_base` to form an 8-bit code. That code selects gaps from 104 up to 2144 bit times in 8-bit-time steps. The block reads the configuration only at the moment a gap starts.

The controller has two states. In ST_OPEN the permit is high. In ST_HOLD the permit is low.
- T_START (ST_OPEN to ST_HOLD) is taken on `tx_end`.
- T_RESTART (ST_HOLD to ST_HOLD) is taken on `tx_end` during a gap and reloads the counter.
- T_EXPIRE (ST_HOLD to ST_OPEN) is taken on the tick that brings the counter from one to zero.

Top module: `ipg_gap_timer`

## Requirements
- R1: During and after reset, before any `tx_end`, `tx_permit` is 1.
- R2: A `tx_end` sampled at a clock edge makes `tx_permit` 0 from that edge on.
- R3: With `ext_en`=0 the gap length in byte times is max(12 − `gap_base`, 5), so code 0 gives 96 bit times and the floor is 40 bit times. In this mode `gap_ext` has no effect.
- R4: With `ext_en`=1 the gap length in byte times is 13 + code, where code = {`gap_ext`, `gap_base`} with `gap_ext` as the upper 3 bits. Code 0 gives 104 bit times, code 1 gives 112 bit times and code 255 (7, 31) gives 2144 bit times.
- R5: `byte_tick` pulses are counted only from the cycle after `tx_end`; a tick in the same cycle as `tx_end` does not count. `tx_permit` becomes 1 at the clock edge that samples the L-th counted tick, where L is the gap length.
- R6: Changing `ext_en`, `gap_base` or `gap_ext` while a gap is running does not change the length of that gap.
- R7: A `tx_end` during a running gap restarts the gap with a full length taken from the configuration at that moment.
- R8: In cycles without `byte_tick` the remaining gap does not change, and `tx_permit` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_tick | input | 1 | One-cycle pulse per byte time at the line rate |
| tx_end | input | 1 | One-cycle pulse when a frame has been fully transmitted |
| ext_en | input | 1 | 1 selects extended gap mode |
| gap_base | input | 5 | Base gap field (lower bits of the gap code) |
| gap_ext | input | 3 | Extension field (upper bits of the gap code, extended mode only) |
| tx_permit | output | 1 | 1 when a new frame may start |

## Verification
Some properties hold on every cycle, and the assertions check those:
- `tx_end` closes the permit on the next cycle.
- The permit rises only right after a counter expiry.
- The remaining count holds when there is no tick, and never grows except on a load.
- The length table stays within the bounds of the selected mode.

Other behaviour is only visible at the ports across a whole gap, so the bench scenarios cover it:
- The exact lengths for the normal-mode floor and for the extended end points 104 and 2144.
- That the extension field is ignored when extended mode is off.
- That a mid-gap configuration change is ignored.
- That a restart during a gap reloads the full length.
- That a tick arriving together with `tx_end` is not counted.

// File: rtl/ipg_gap_pkg.sv
package ipg_gap_pkg;

    typedef enum logic [0:0] {
        ST_OPEN = 1'b0,
        ST_HOLD = 1'b1
    } gap_state_t;

endpackage

// File: rtl/ipg_len_calc.sv
module ipg_len_calc #(
    parameter int BASE_W      = 5,
    parameter int EXT_W       = 3,
    parameter int NORM_BYTES  = 12,
    parameter int EXT_BYTES   = 13,
    parameter int FLOOR_BYTES = 5,
    parameter int CNT_W       = 9
) (
    input  logic              ext_en,
    input  logic [BASE_W-1:0] gap_base,
    input  logic [EXT_W-1:0]  gap_ext,
    output logic [CNT_W-1:0]  gap_len
);
    localparam int CODE_W = BASE_W + EXT_W;
    localparam int KNEE   = NORM_BYTES - FLOOR_BYTES;

    logic [CODE_W-1:0] code;

    assign code = {gap_ext, gap_base};

    always_comb begin
        if (ext_en) begin
            gap_len = CNT_W'(EXT_BYTES) + CNT_W'(code);
        end else if (int'(gap_base) >= KNEE) begin
            gap_len = CNT_W'(FLOOR_BYTES);
        end else begin
            gap_len = CNT_W'(NORM_BYTES) - CNT_W'(gap_base);
        end
    end

    // R3: normal mode stays between the floor and the 96-bit-time ceiling
    always_comb begin
        if (!ext_en) begin
            assert_norm_range_R3: assert (int'(gap_len) >= FLOOR_BYTES && int'(gap_len) <= NORM_BYTES);
        end
    end

    // R4: extended mode never drops below 104 bit times
    always_comb begin
        if (ext_en) begin
            assert_ext_floor_R4: assert (int'(gap_len) >= EXT_BYTES);
        end
    end

endmodule

// File: rtl/ipg_gap_cnt.sv
module ipg_gap_cnt #(
    parameter int CNT_W   = 9,
    parameter int MAX_LEN = 268
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= len;
        end else if (dec && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expire = dec && !load && (remain == CNT_W'(1));

    // R8: without a tick or load the remaining count holds
    assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(remain));

    // R6: the count never grows except through a load
    assert_no_growth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> remain <= $past(remain));

    // R4: the count never exceeds the largest extended length
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(remain) <= MAX_LEN);

endmodule

// File: rtl/ipg_gap_fsm.sv
module ipg_gap_fsm
    import ipg_gap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_end,
    input  logic expire,
    output logic load,
    output logic tx_permit
);
    gap_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OPEN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OPEN: begin
                if (tx_end) state_nx = ST_HOLD;        // T_START
            end
            ST_HOLD: begin
                if (tx_end)      state_nx = ST_HOLD;   // T_RESTART
                else if (expire) state_nx = ST_OPEN;   // T_EXPIRE
            end
            default: state_nx = ST_OPEN;
        endcase
    end

    always_comb begin
        load      = tx_end;
        tx_permit = (state == ST_OPEN);
    end

    // R2: end of frame closes the permit at the next cycle
    assert_end_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end |=> !tx_permit);

    // R5: permit only reopens right after a counter expiry
    assert_rise_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_permit) |-> $past(expire));

endmodule

// File: rtl/ipg_gap_timer.sv
module ipg_gap_timer #(
    parameter int BASE_W      = 5,
    parameter int EXT_W       = 3,
    parameter int NORM_BYTES  = 12,
    parameter int EXT_BYTES   = 13,
    parameter int FLOOR_BYTES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_tick,
    input  logic              tx_end,
    input  logic              ext_en,
    input  logic [BASE_W-1:0] gap_base,
    input  logic [EXT_W-1:0]  gap_ext,
    output logic              tx_permit
);
    localparam int MAX_LEN = EXT_BYTES + (2 ** (BASE_W + EXT_W)) - 1;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] gap_len;
    logic             load;
    logic             expire;

    ipg_len_calc #(
        .BASE_W      (BASE_W),
        .EXT_W       (EXT_W),
        .NORM_BYTES  (NORM_BYTES),
        .EXT_BYTES   (EXT_BYTES),
        .FLOOR_BYTES (FLOOR_BYTES),
        .CNT_W       (CNT_W)
    ) u_len (
        .ext_en   (ext_en),
        .gap_base (gap_base),
        .gap_ext  (gap_ext),
        .gap_len  (gap_len)
    );

    ipg_gap_cnt #(
        .CNT_W   (CNT_W),
        .MAX_LEN (MAX_LEN)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .dec    (byte_tick),
        .len    (gap_len),
        .expire (expire)
    );

    ipg_gap_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_end    (tx_end),
        .expire    (expire),
        .load      (load),
        .tx_permit (tx_permit)
    );

endmodule

// File: tb/ipg_gap_timer_bench.sv
module ipg_gap_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_tick = 1'b0;
    logic       tx_end = 1'b0;
    logic       ext_en = 1'b0;
    logic [4:0] gap_base = '0;
    logic [2:0] gap_ext = '0;
    logic       tx_permit;

    int total = 0;
    int bad = 0;
    int exp_q[$];
    string tag_q[$];
    bit measuring = 0;
    int ticks_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipg_gap_timer u_ipg_gap_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_tick (byte_tick),
        .tx_end    (tx_end),
        .ext_en    (ext_en),
        .gap_base  (gap_base),
        .gap_ext   (gap_ext),
        .tx_permit (tx_permit)
    );

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: count ticks after each tx_end at the edges
    always @(posedge clk) begin
        if (rst_n) begin
            if (tx_end) begin
                measuring  = 1;
                ticks_seen = 0;
            end else if (measuring && byte_tick) begin
                ticks_seen++;
            end
        end
    end

    // monitor: when permit reopens, compare against the scoreboard
    always @(negedge clk) begin
        if (rst_n && measuring && tx_permit) begin
            measuring = 0;
            if (exp_q.size() == 0) begin
                check("R5 unexpected reopen", ticks_seen, -1);
            end else begin
                automatic int e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, ticks_seen, e);
            end
        end
    end

    // driver: one gap; every = tick spacing, swap = change config mid-gap
    task automatic run_gap(input string req, input bit en, input int b, input int e,
                           input int expl, input int every, input bit swap, input bit tick_at_end);
        @(negedge clk);
        ext_en = en; gap_base = 5'(b); gap_ext = 3'(e);
        tx_end = 1'b1; byte_tick = tick_at_end;
        exp_q.push_back(expl); tag_q.push_back(req);
        @(negedge clk);
        tx_end = 1'b0; byte_tick = 1'b0;
        check("R2 permit low after end", int'(tx_permit), 0);
        for (int k = 0; k < 4000 && !tx_permit; k++) begin
            byte_tick = ((k % every) == (every - 1));
            if (swap && k == 2) begin
                ext_en = ~en; gap_base = ~gap_base; gap_ext = ~gap_ext;
            end
            @(negedge clk);
        end
        byte_tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 permit in reset", int'(tx_permit), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 permit after reset", int'(tx_permit), 1);

        run_gap("R3 code0 96bt", 0, 0, 0, 12, 1, 0, 0);
        run_gap("R3 code6", 0, 6, 0, 6, 1, 0, 0);
        run_gap("R3 floor code7", 0, 7, 0, 5, 1, 0, 0);
        run_gap("R3 floor code31", 0, 31, 0, 5, 2, 0, 0);
        run_gap("R3 ext ignored", 0, 3, 7, 9, 1, 0, 0);
        run_gap("R4 ext code0 104bt", 1, 0, 0, 13, 1, 0, 0);
        run_gap("R4 ext code1 112bt", 1, 1, 0, 14, 3, 0, 0);
        run_gap("R4 ext code69", 1, 5, 2, 82, 1, 0, 0);
        run_gap("R4 ext max 2144bt", 1, 31, 7, 268, 1, 0, 0);
        run_gap("R5 tick with end ignored", 0, 0, 0, 12, 1, 0, 1);
        run_gap("R6 config swap mid-gap", 0, 2, 0, 10, 1, 1, 0);
        run_gap("R8 sparse ticks", 1, 2, 0, 15, 7, 0, 0);

        // R8: no ticks for a while, permit must stay low
        @(negedge clk);
        ext_en = 0; gap_base = 0; tx_end = 1'b1;
        @(negedge clk);
        tx_end = 1'b0;
        repeat (30) @(negedge clk);
        check("R8 no tick keeps permit low", int'(tx_permit), 0);
        // R7: restart mid-gap with new configuration (first gap aborted)
        repeat (3) begin
            byte_tick = 1'b1; @(negedge clk);
        end
        byte_tick = 1'b0;
        check("R7 still closed before restart", int'(tx_permit), 0);
        run_gap("R7 restart full length", 1, 3, 0, 16, 1, 0, 0);

        check("scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule